// File: doc/BRIEF.md
# Receive Ring Buffer Controller

This block runs the device side of a single receive ring kept in host memory. Software fills a power-of-two ring with one-word entries, each holding a 256-byte-aligned buffer address. It then moves a write index forward to publish those entries. The controller reads each entry through a descriptor read port and offers the buffer to the incoming-frame path as an address and a byte capacity. A buffer is closed when the frame path reports it full, when a frame ends while an end-of-frame pause is requested, or when no new frame has arrived for a programmed number of 32 µs ticks. On each close the controller writes the ring index of the closed entry to the status location and, if enabled, pulses a host interrupt.

A single configuration word sets the channel mode, ring size, buffer size, interrupt routing and timeout. An idle output lets software confirm that the channel has come to rest after it stops or pauses the channel. Moving frame data into the buffers is done elsewhere.

Top module: `rx_ring_ctrl`

## Requirements
- R1: Configuration bits 23:20 give log2 of the ring length. The value is clamped to the range 5..12. The read and write indices wrap modulo that length, so after entry 2^N-1 the next entry handed out is entry 0.
- R2: An offered buffer has bufAddr equal to the entry word shifted left by 8, with the low 8 bits zero. Its bufBytes is (code+1)*4096, where code is configuration bits 17:16 (00=4K, 01=8K, 10=12K, 11=16K).
- R3: The write index marks one past the last published entry. When the read index equals the write index, no buffer is fetched or offered, so at most ring length minus 1 entries are outstanding.
- R4: A host write index whose low 3 bits are not zero is rounded down to a multiple of 8. It also sets the misuse output, which stays set until reset.
- R5: A frameDone with frameFull=1 on an open buffer closes it. On the next clock statWrEn pulses for one cycle, and statWrIdx holds the index of the closed entry in its 12 bits.
- R6: Each tick32us pulse after the first frame in the open buffer advances a timeout count. The buffer closes (with a status write) on the tick that brings the count to configuration bits 11:4. Any frameDone that does not close the buffer restarts the count, and ticks before the first frame are ignored.
- R7: irq pulses in the same cycle as statWrEn if configuration bits 13:12 equal 01, and stays low otherwise.
- R8: Channel mode is configuration bits 31:30. In mode 10 buffers are fetched and filled normally. In mode 01 no new buffer is fetched, and the next frameDone closes the open buffer.
- R9: In mode 00 (and in the unused mode 11) frameDone and tick32us are ignored and bufValid is low. An open buffer is kept, and it is offered again unchanged when mode 10 returns.
- R10: idle is high when the mode is not 10, no entry read is in flight, and either the mode is not 01 or no buffer is open.
- R11: An entry read asserts descRdEn with descRdIdx equal to the read index. The entry word is taken from descRdData one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWord | input | 32 | Mode, ring size, buffer size, interrupt routing, timeout |
| hostWrIdx | input | 12 | Host write index value |
| hostWrStb | input | 1 | Loads hostWrIdx |
| descRdEn | output | 1 | Ring entry read request |
| descRdIdx | output | 12 | Ring index being read |
| descRdData | input | 28 | Entry word, valid one clock after descRdEn |
| bufValid | output | 1 | A buffer is open and offered |
| bufAddr | output | 36 | Physical address of the offered buffer |
| bufBytes | output | 15 | Capacity of the offered buffer in bytes |
| frameDone | input | 1 | A frame has landed in the open buffer |
| frameFull | input | 1 | With frameDone: the buffer has no room left |
| tick32us | input | 1 | One-cycle pulse every 32 µs |
| statWrEn | output | 1 | Status location write strobe |
| statWrIdx | output | 12 | Index of the last filled entry |
| irq | output | 1 | Host interrupt pulse |
| idle | output | 1 | Channel at rest |
| misuse | output | 1 | Sticky misaligned write index flag |

## Verification
Frame arrival and timeout expiry can land in the same clock. The bench lets a partly filled buffer's count reach one tick short of the limit, then drives a non-full frameDone together with the tick that would expire it. The frame must win: no status write may appear. The buffer must survive a further limit-minus-one ticks and close only on the tick that completes a fresh count, and the scoreboard must receive exactly one index for it.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [1:0] {
    EN_STOP      = 2'b00,
    EN_PAUSE_EOF = 2'b01,
    EN_RUN       = 2'b10,
    EN_RSVD      = 2'b11
  } chanMode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_OPEN = 2'd2
  } ringState_e;

  typedef struct packed {
    logic fetch;
    logic load;
    logic close;
    logic irq;
  } dpStrobe_t;

  localparam int CFG_MODE_LSB = 30;
  localparam int CFG_LOG_LSB  = 20;
  localparam int CFG_SIZE_LSB = 16;
  localparam int CFG_DEST_LSB = 12;
  localparam int CFG_TMO_LSB  = 4;
  localparam int CFG_TMO_W    = 8;
  localparam logic [1:0] IRQ_TO_HOST = 2'b01;

endpackage

// File: rtl/rxr_datapath.sv
module rxr_datapath
  import rxr_pkg::*;
#(
  parameter int IDX_W    = 12,
  parameter int DESC_W   = 28,
  parameter int ALIGN_SH = 8,
  parameter int STEP_LOG = 3,
  parameter int MIN_LOG  = 5,
  parameter int MAX_LOG  = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [3:0]                 ringLog,
  input  logic [IDX_W-1:0]           hostWrIdx,
  input  logic                       hostWrStb,
  input  logic [DESC_W-1:0]          descRdData,
  input  dpStrobe_t                  strobe,
  output logic                       ringEmpty,
  output logic [IDX_W-1:0]           descRdIdx,
  output logic [DESC_W+ALIGN_SH-1:0] bufAddr,
  output logic                       statWrEn,
  output logic [IDX_W-1:0]           statWrIdx,
  output logic                       irq,
  output logic                       misuse
);

  localparam logic [IDX_W-1:0] STEP_MASK = {IDX_W{1'b1}} << STEP_LOG;

  logic [3:0]        logEff;
  logic [IDX_W-1:0]  ringMask;
  logic [IDX_W-1:0]  rdIdx, wrIdx, curIdx;
  logic [DESC_W-1:0] curDesc;
  logic              misaligned;

  always_comb begin
    if (ringLog < 4'(MIN_LOG))      logEff = 4'(MIN_LOG);
    else if (ringLog > 4'(MAX_LOG)) logEff = 4'(MAX_LOG);
    else                            logEff = ringLog;
    ringMask   = ~({IDX_W{1'b1}} << logEff);
    misaligned = hostWrIdx[STEP_LOG-1:0] != '0;
  end

  assign ringEmpty = rdIdx == wrIdx;
  assign descRdIdx = rdIdx;
  assign bufAddr   = {curDesc, {ALIGN_SH{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx  <= '0;
      misuse <= 1'b0;
    end else if (hostWrStb) begin
      wrIdx <= hostWrIdx & ringMask & STEP_MASK;
      if (misaligned) misuse <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdIdx   <= '0;
      curIdx  <= '0;
      curDesc <= '0;
    end else if (strobe.load) begin
      rdIdx   <= (rdIdx + 1'b1) & ringMask;
      curIdx  <= rdIdx;
      curDesc <= descRdData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statWrEn  <= 1'b0;
      statWrIdx <= '0;
      irq       <= 1'b0;
    end else begin
      statWrEn <= strobe.close;
      irq      <= strobe.irq;
      if (strobe.close) statWrIdx <= curIdx;
    end
  end

  assert_no_fetch_when_empty_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fetch |-> (rdIdx != wrIdx));

  assert_misuse_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    misuse |=> misuse);

endmodule

// File: rtl/rxr_control.sv
module rxr_control
  import rxr_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanMode_e        mode,
  input  logic [TMO_W-1:0] tmoLimit,
  input  logic [1:0]       irqDest,
  input  logic             ringEmpty,
  input  logic             frameDone,
  input  logic             frameFull,
  input  logic             tick,
  output dpStrobe_t        strobe,
  output logic             bufValid,
  output logic             idle
);

  ringState_e       state, nextState;
  logic             run, active, hasFrame, tmoHit;
  logic [TMO_W-1:0] tmoCnt;

  always_comb begin
    run    = mode == EN_RUN;
    active = run || (mode == EN_PAUSE_EOF);
    tmoHit = tick && hasFrame && (tmoLimit != '0) &&
             (({1'b0, tmoCnt} + (TMO_W+1)'(1)) == {1'b0, tmoLimit});
    strobe    = '0;
    nextState = state;
    unique case (state)
      S_IDLE: if (run && !ringEmpty) begin
        strobe.fetch = 1'b1;
        nextState    = S_WAIT;
      end
      S_WAIT: begin
        strobe.load = 1'b1;
        nextState   = S_OPEN;
      end
      S_OPEN: if (active) begin
        if (frameDone) strobe.close = frameFull || (mode == EN_PAUSE_EOF);
        else           strobe.close = tmoHit;
        if (strobe.close) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
    strobe.irq = strobe.close && (irqDest == IRQ_TO_HOST);
  end

  assign bufValid = (state == S_OPEN) && active;
  assign idle     = !run && (state != S_WAIT) &&
                    ((mode != EN_PAUSE_EOF) || (state == S_IDLE));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      hasFrame <= 1'b0;
      tmoCnt   <= '0;
    end else begin
      state <= nextState;
      if (strobe.load || strobe.close) begin
        hasFrame <= 1'b0;
        tmoCnt   <= '0;
      end else if (state == S_OPEN && active && frameDone) begin
        hasFrame <= 1'b1;
        tmoCnt   <= '0;
      end else if (state == S_OPEN && active && tick && hasFrame) begin
        tmoCnt <= tmoCnt + 1'b1;
      end
    end
  end

  assert_stop_keeps_buffer_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_OPEN && !active) |=> (state == S_OPEN));

  assert_close_drops_offer_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.close |=> !bufValid);

  assert_load_follows_fetch_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fetch |=> strobe.load);

endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rxr_pkg::*;
#(
  parameter int IDX_W    = 12,
  parameter int DESC_W   = 28,
  parameter int ALIGN_SH = 8,
  parameter int STEP_LOG = 3,
  parameter int MIN_LOG  = 5,
  parameter int MAX_LOG  = 12,
  parameter int SIZE_SH  = 12,
  localparam int ADDR_W  = DESC_W + ALIGN_SH,
  localparam int BYTES_W = SIZE_SH + 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [31:0]        cfgWord,
  input  logic [IDX_W-1:0]   hostWrIdx,
  input  logic               hostWrStb,
  output logic               descRdEn,
  output logic [IDX_W-1:0]   descRdIdx,
  input  logic [DESC_W-1:0]  descRdData,
  output logic               bufValid,
  output logic [ADDR_W-1:0]  bufAddr,
  output logic [BYTES_W-1:0] bufBytes,
  input  logic               frameDone,
  input  logic               frameFull,
  input  logic               tick32us,
  output logic               statWrEn,
  output logic [IDX_W-1:0]   statWrIdx,
  output logic               irq,
  output logic               idle,
  output logic               misuse
);

  chanMode_e            mode;
  logic [3:0]           ringLog;
  logic [1:0]           sizeCode, irqDest;
  logic [2:0]           sizeUnits;
  logic [CFG_TMO_W-1:0] tmoLimit;
  logic                 unusedCfgBits;
  dpStrobe_t            strobe;
  logic                 ringEmpty;

  assign mode      = chanMode_e'(cfgWord[CFG_MODE_LSB +: 2]);
  assign ringLog   = cfgWord[CFG_LOG_LSB +: 4];
  assign sizeCode  = cfgWord[CFG_SIZE_LSB +: 2];
  assign irqDest   = cfgWord[CFG_DEST_LSB +: 2];
  assign tmoLimit  = cfgWord[CFG_TMO_LSB +: CFG_TMO_W];
  assign unusedCfgBits = ^{cfgWord[29:24], cfgWord[19:18], cfgWord[15:14], cfgWord[3:0]};

  assign sizeUnits = {1'b0, sizeCode} + 3'd1;
  assign bufBytes  = {sizeUnits, {SIZE_SH{1'b0}}};
  assign descRdEn  = strobe.fetch;

  rxr_control #(.TMO_W(CFG_TMO_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .mode      (mode),
    .tmoLimit  (tmoLimit),
    .irqDest   (irqDest),
    .ringEmpty (ringEmpty),
    .frameDone (frameDone),
    .frameFull (frameFull),
    .tick      (tick32us),
    .strobe    (strobe),
    .bufValid  (bufValid),
    .idle      (idle)
  );

  rxr_datapath #(
    .IDX_W    (IDX_W),
    .DESC_W   (DESC_W),
    .ALIGN_SH (ALIGN_SH),
    .STEP_LOG (STEP_LOG),
    .MIN_LOG  (MIN_LOG),
    .MAX_LOG  (MAX_LOG)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ringLog    (ringLog),
    .hostWrIdx  (hostWrIdx),
    .hostWrStb  (hostWrStb),
    .descRdData (descRdData),
    .strobe     (strobe),
    .ringEmpty  (ringEmpty),
    .descRdIdx  (descRdIdx),
    .bufAddr    (bufAddr),
    .statWrEn   (statWrEn),
    .statWrIdx  (statWrIdx),
    .irq        (irq),
    .misuse     (misuse)
  );

  assert_irq_with_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> statWrEn);

endmodule

// File: tb/sim_rx_ring_ctrl.sv
module sim_rx_ring_ctrl;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] cfgWord;
  logic [11:0] hostWrIdx;
  logic        hostWrStb;
  logic        descRdEn;
  logic [11:0] descRdIdx;
  logic [27:0] descRdData;
  logic        bufValid;
  logic [35:0] bufAddr;
  logic [14:0] bufBytes;
  logic        frameDone, frameFull, tick32us;
  logic        statWrEn;
  logic [11:0] statWrIdx;
  logic        irq, idle, misuse;

  always #2 clk = ~clk;

  rx_ring_ctrl u0 (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .hostWrIdx(hostWrIdx),
    .hostWrStb(hostWrStb), .descRdEn(descRdEn), .descRdIdx(descRdIdx),
    .descRdData(descRdData), .bufValid(bufValid), .bufAddr(bufAddr),
    .bufBytes(bufBytes), .frameDone(frameDone), .frameFull(frameFull),
    .tick32us(tick32us), .statWrEn(statWrEn), .statWrIdx(statWrIdx),
    .irq(irq), .idle(idle), .misuse(misuse)
  );

  typedef struct {
    logic [11:0] idx;
    logic        irq;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t got;
  int  nCmp = 0;
  int  nBad = 0;
  bit  done = 1'b0;
  logic irqNow;

  function automatic logic [27:0] descOf(input logic [11:0] i);
    return 28'h0100005 + 28'(i) * 28'd7;
  endfunction

  function automatic logic [31:0] mkCfg(input logic [1:0] en, input logic [3:0] lg,
                                        input logic [1:0] sz, input logic [1:0] dst,
                                        input logic [7:0] tmo);
    return {en, 6'b0, lg, 2'b0, sz, 2'b0, dst, tmo, 4'b0};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  // entry memory with one cycle read latency (R11)
  always @(posedge clk) if (descRdEn) descRdData <= descOf(descRdIdx);

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN === 1'b1 && !done) begin
      if (statWrEn === 1'b1) begin
        if (expQ.size() == 0) begin
          nCmp++; nBad++;
          $display("FAIL R5 unexpected status write actual=%0h expected=none", statWrIdx);
        end else begin
          got = expQ.pop_front();
          chk("R5 status index", 64'(statWrIdx), 64'(got.idx));
          chk("R7 irq with status", 64'(irq), 64'(got.irq));
        end
      end else if (irq === 1'b1) begin
        chk("R7 irq without status", 64'(irq), 64'd0);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [11:0] v);
    @(negedge clk); hostWrIdx = v; hostWrStb = 1'b1;
    @(negedge clk); hostWrStb = 1'b0;
  endtask

  task automatic frame(input logic full, input bit push, input logic [11:0] idx);
    @(negedge clk); frameDone = 1'b1; frameFull = full;
    if (push) expQ.push_back('{idx: idx, irq: irqNow});
    @(negedge clk); frameDone = 1'b0; frameFull = 1'b0;
  endtask

  task automatic tickN(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick32us = 1'b1;
      @(negedge clk); tick32us = 1'b0;
    end
  endtask

  task automatic waitOpen(input string tag, input logic [11:0] idx);
    for (int k = 0; k < 10 && bufValid !== 1'b1; k++) @(negedge clk);
    chk({tag, " buffer offered"}, 64'(bufValid), 64'd1);
    chk({tag, " buffer address"}, 64'(bufAddr), 64'({descOf(idx), 8'h00}));
  endtask

  initial begin
    #400000;
    nBad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1'b1;
    summary();
  end

  initial begin
    rstN = 1'b0; cfgWord = '0; hostWrIdx = '0; hostWrStb = 1'b0;
    frameDone = 1'b0; frameFull = 1'b0; tick32us = 1'b0; descRdData = '0;
    irqNow = 1'b1;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    chk("R10 reset idle", 64'(idle), 64'd1);
    chk("R9 reset no offer", 64'(bufValid), 64'd0);
    chk("R5 reset no status", 64'(statWrEn), 64'd0);
    chk("R4 reset misuse", 64'(misuse), 64'd0);
    chk("R11 reset no read", 64'(descRdEn), 64'd0);

    // run, 32 entries, 8K buffers, interrupt to host, timeout 3 ticks
    cfgWord = mkCfg(2'b10, 4'd5, 2'b01, 2'b01, 8'd3);
    cyc(5);
    chk("R3 empty ring offers nothing", 64'(bufValid), 64'd0);
    chk("R10 running not idle", 64'(idle), 64'd0);

    hostWrite(12'd8);
    waitOpen("R11 first entry", 12'd0);
    chk("R2 buffer bytes 8K", 64'(bufBytes), 64'd8192);
    frame(1'b1, 1'b1, 12'd0);

    // timeout close, ticks before a frame ignored
    waitOpen("R6 entry1", 12'd1);
    tickN(5);
    chk("R6 ticks before frame ignored", 64'(bufValid), 64'd1);
    frame(1'b0, 1'b0, 12'd0);
    tickN(2);
    chk("R6 still open before limit", 64'(bufValid), 64'd1);
    expQ.push_back('{idx: 12'd1, irq: 1'b1});
    tickN(1);

    // frame and expiring tick in the same cycle: frame restarts count
    waitOpen("R6 entry2", 12'd2);
    frame(1'b0, 1'b0, 12'd0);
    tickN(2);
    @(negedge clk); frameDone = 1'b1; tick32us = 1'b1;
    @(negedge clk); frameDone = 1'b0; tick32us = 1'b0;
    tickN(2);
    chk("R6 restart kept buffer open", 64'(bufValid), 64'd1);
    chk("R6 restart buffer unchanged", 64'(bufAddr), 64'({descOf(12'd2), 8'h00}));
    expQ.push_back('{idx: 12'd2, irq: 1'b1});
    tickN(1);

    for (int i = 3; i < 8; i++) begin
      waitOpen("R5 fill", 12'(i));
      frame(1'b1, 1'b1, 12'(i));
    end
    cyc(5);
    chk("R3 read caught write", 64'(bufValid), 64'd0);
    chk("R3 no read when empty", 64'(descRdEn), 64'd0);

    hostWrite(12'd13);
    cyc(5);
    chk("R4 misuse flagged", 64'(misuse), 64'd1);
    chk("R4 index rounded down", 64'(bufValid), 64'd0);

    hostWrite(12'd16);
    for (int i = 8; i < 16; i++) begin
      waitOpen("R5 fill", 12'(i));
      frame(1'b1, 1'b1, 12'(i));
    end
    hostWrite(12'd0);
    for (int i = 16; i < 32; i++) begin
      waitOpen("R1 fill to end", 12'(i));
      frame(1'b1, 1'b1, 12'(i));
    end
    cyc(5);
    chk("R1 wrap stops at write index", 64'(bufValid), 64'd0);
    chk("R4 misuse remains", 64'(misuse), 64'd1);

    hostWrite(12'd8);
    waitOpen("R1 wrapped to entry0", 12'd0);

    // pause at end of frame
    cfgWord = mkCfg(2'b01, 4'd5, 2'b11, 2'b01, 8'd3);
    cyc(2);
    chk("R10 pause with open buffer not idle", 64'(idle), 64'd0);
    chk("R8 open buffer still offered in pause", 64'(bufValid), 64'd1);
    chk("R2 buffer bytes 16K", 64'(bufBytes), 64'd16384);
    frame(1'b0, 1'b1, 12'd0);
    cyc(5);
    chk("R8 no new buffer in pause", 64'(bufValid), 64'd0);
    chk("R10 paused idle", 64'(idle), 64'd1);

    cfgWord = mkCfg(2'b10, 4'd5, 2'b11, 2'b01, 8'd3);
    waitOpen("R8 resume", 12'd1);

    // stop at once
    cfgWord = mkCfg(2'b00, 4'd5, 2'b11, 2'b01, 8'd3);
    cyc(1);
    chk("R10 stop idle", 64'(idle), 64'd1);
    chk("R9 stop hides buffer", 64'(bufValid), 64'd0);
    frame(1'b1, 1'b0, 12'd0);
    frame(1'b0, 1'b0, 12'd0);
    tickN(5);
    cyc(3);
    cfgWord = mkCfg(2'b10, 4'd5, 2'b11, 2'b00, 8'd3);
    irqNow = 1'b0;
    waitOpen("R9 buffer kept through stop", 12'd1);
    frame(1'b1, 1'b1, 12'd1);
    waitOpen("R7 no-irq routing", 12'd2);
    frame(1'b1, 1'b1, 12'd2);

    cyc(6);
    chk("R5 all expected status writes seen", 64'(expQ.size()), 64'd0);
    done = 1'b1;
    summary();
  end

endmodule